// File: doc/BRIEF.md
# Descriptor Ring DMA Engine

This engine moves Ethernet-style frames between two byte streams and a buffer memory. It uses two rings of buffer descriptors, one for receive and one for transmit. Both rings live in a small descriptor store inside the block, and the host reads and writes that store through a single word port. Each descriptor takes two 32-bit words. The first word holds a 16-bit status/control half in bits 31:16 and a 16-bit length in bits 15:0. The second word holds a 32-bit buffer byte address. Descriptor `d` occupies words `2d` and `2d+1`.

Software hands a descriptor to the engine by setting its ownership bit (status bit 15). On a receive descriptor this bit means "empty"; on a transmit descriptor it means "ready". Software then writes the ring's activation register. The engine works through owned descriptors one after another. For each one it moves the data, then writes length and status back in a single whole-word store, and then moves to the next descriptor. If status bit 13 (wrap) is set on the descriptor just finished, the next descriptor is the ring's start index. The engine stops a ring when it meets a descriptor it does not own, and the ring stays stopped until it is activated again. Receive and transmit share one sequencer. A waiting receive frame takes precedence over transmit work.

Host register space is selected by the top host address bit. Offset 0 is the receive start index and offset 1 is the transmit start index. Offset 2 is receive activation and offset 3 is transmit activation. Reading an activation offset returns bit 24 set while that ring is running.

Top module: `bdring_dma`

## Requirements
- R1: After reset both rings are stopped: the activation readbacks are 0, `rx_ready`, `tx_valid` and `mem_req` are low, and the start indices read 0.
- R2: A write to an activation register with bit 24 set (value 0x01000000) starts that ring. A write with bit 24 clear has no effect: the ring stays stopped and accepts no bytes.
- R3: Byte i of a received frame is written to buffer address pointer+i in arrival order. The written length counts every byte of the frame, the trailing 4-byte check sequence included.
- R4: Receive write-back clears the empty bit 15, sets the last bit 11 and keeps the wrap bit 13. The six error flags are bits 5:0: bit 2 is set when `rx_fcs_bad` accompanied the final byte, and all six are zero for a good frame.
- R5: On reaching a receive descriptor whose empty bit is clear, the engine stops the ring. `rx_ready` then stays low and the readback shows 0 until the activation register is written again.
- R6: Only the first MAX_BUF (1520) bytes of a frame are stored, and the length is capped at MAX_BUF. Error bit 5 is set exactly when the frame is longer than MAX_FRAME (1518) bytes.
- R7: After a descriptor with the wrap bit set, the next descriptor used is the ring's start index. Otherwise the next one is the following index, modulo NDESC.
- R8: A transmit descriptor of length L sends the bytes at pointer..pointer+L-1 in order. `tx_last` is raised on the final byte only when status bit 11 is set. Output holds stable while `tx_ready` is low.
- R9: Transmit write-back clears the ready bit 15 and leaves every other status bit and the length unchanged.
- R10: On reaching a transmit descriptor whose ready bit is clear, the engine stops the transmit ring and drives no more output.
- R11: Writing a start index register moves that ring's position to the new index.
- R12: A ready transmit descriptor with length 0 sends no byte and is still released with bit 15 cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Host write strobe |
| host_addr | input | 5 | Host word address; top bit selects registers |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data (combinational) |
| mem_req | output | 1 | Buffer memory access this cycle |
| mem_we | output | 1 | Access is a byte write |
| mem_addr | output | 32 | Buffer byte address |
| mem_wdata | output | 8 | Byte to write |
| mem_rdata | input | 8 | Read byte, valid by the end of the request cycle |
| rx_valid | input | 1 | Receive byte present |
| rx_data | input | 8 | Receive byte |
| rx_last | input | 1 | Final byte of the frame |
| rx_fcs_bad | input | 1 | Check-sequence failure, sampled with the final byte |
| rx_ready | output | 1 | Engine accepts a receive byte |
| tx_valid | output | 1 | Transmit byte present |
| tx_data | output | 8 | Transmit byte |
| tx_last | output | 1 | Final byte of the frame |
| tx_ready | input | 1 | Sink accepts the transmit byte |

## Verification
A wrong ring position or ownership decision shows up within one descriptor. Either a frame lands in the wrong buffer, or a status word keeps its ownership bit, or the engine stops or fails to stop. All of these are visible at the next descriptor readback or at `rx_ready`. A wrong byte count or truncation limit shows up in the written length and error flags at the end of that frame, and in a buffer byte past the limit that should be untouched. Transmit sequencing errors show up byte by byte against the expected stream, including where `tx_last` falls and whether a zero-length descriptor is released.

// File: rtl/bdring_pkg.sv
package bdring_pkg;
    localparam int OWN_BIT  = 15;
    localparam int WRAP_BIT = 13;
    localparam int LAST_BIT = 11;
    localparam int ELEN_BIT = 5;
    localparam int EFCS_BIT = 2;
    localparam int KICK_BIT = 24;

    typedef enum logic [2:0] {
        S_IDLE, S_RX_FETCH, S_RX_DATA, S_RX_WB,
        S_TX_FETCH, S_TX_RD, S_TX_OUT, S_TX_WB
    } eng_state_e;
endpackage

// File: rtl/bdring_desc_ram.sv
module bdring_desc_ram #(
    parameter int NDESC = 8,
    localparam int IW  = $clog2(2 * NDESC),
    localparam int DIW = $clog2(NDESC)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           host_we,
    input  logic [IW-1:0]  host_idx,
    input  logic [31:0]    host_wdata,
    output logic [31:0]    host_rdata,
    input  logic [DIW-1:0] eng_idx,
    output logic [31:0]    eng_w0,
    output logic [31:0]    eng_w1,
    input  logic           wb_we,
    input  logic [DIW-1:0] wb_idx,
    input  logic [31:0]    wb_word
);
    logic [31:0] words_q [2*NDESC];
    logic [31:0] words_d [2*NDESC];

    always_comb begin
        for (int i = 0; i < 2 * NDESC; i++) words_d[i] = words_q[i];
        if (wb_we) words_d[{wb_idx, 1'b0}] = wb_word;
        // host store is applied last so it wins a same-word collision
        if (host_we) words_d[host_idx] = host_wdata;
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < 2 * NDESC; i++)
            words_q[i] <= rst_n ? words_d[i] : 32'h0;
    end

    assign host_rdata = words_q[host_idx];
    assign eng_w0     = words_q[{eng_idx, 1'b0}];
    assign eng_w1     = words_q[{eng_idx, 1'b1}];
endmodule

// File: rtl/bdring_regs.sv
module bdring_regs #(
    parameter int DIW = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic [1:0]     sel,
    input  logic           kick_bit,
    input  logic [DIW-1:0] idx_in,
    output logic [DIW-1:0] rx_base,
    output logic [DIW-1:0] tx_base,
    output logic           rx_kick,
    output logic           tx_kick,
    output logic           rx_rebase,
    output logic           tx_rebase
);
    typedef struct packed {
        logic [DIW-1:0] rx_base;
        logic [DIW-1:0] tx_base;
    } regs_t;

    regs_t q, d;

    always_comb begin
        d         = q;
        rx_kick   = 1'b0;
        tx_kick   = 1'b0;
        rx_rebase = 1'b0;
        tx_rebase = 1'b0;
        if (wr_en) begin
            unique case (sel)
                2'd0: begin d.rx_base = idx_in; rx_rebase = 1'b1; end
                2'd1: begin d.tx_base = idx_in; tx_rebase = 1'b1; end
                2'd2: rx_kick = kick_bit;
                2'd3: tx_kick = kick_bit;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rx_base = q.rx_base;
    assign tx_base = q.tx_base;
endmodule

// File: rtl/bdring_engine.sv
module bdring_engine
    import bdring_pkg::*;
#(
    parameter int NDESC     = 8,
    parameter int MAX_BUF   = 1520,
    parameter int MAX_FRAME = 1518,
    localparam int DIW = $clog2(NDESC)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           rx_kick,
    input  logic           tx_kick,
    input  logic           rx_rebase,
    input  logic           tx_rebase,
    input  logic [DIW-1:0] rebase_idx,
    input  logic [DIW-1:0] rx_base,
    input  logic [DIW-1:0] tx_base,
    output logic [DIW-1:0] desc_idx,
    input  logic [31:0]    w0,
    input  logic [31:0]    w1,
    output logic           wb_we,
    output logic [DIW-1:0] wb_idx,
    output logic [31:0]    wb_word,
    output logic           mem_req,
    output logic           mem_we,
    output logic [31:0]    mem_addr,
    output logic [7:0]     mem_wdata,
    input  logic [7:0]     mem_rdata,
    input  logic           rx_valid,
    input  logic [7:0]     rx_data,
    input  logic           rx_last,
    input  logic           rx_fcs_bad,
    output logic           rx_ready,
    output logic           tx_valid,
    output logic [7:0]     tx_data,
    output logic           tx_last,
    input  logic           tx_ready,
    output logic           rx_run,
    output logic           tx_run
);
    localparam logic [15:0] BUF_LIM   = 16'(MAX_BUF);
    localparam logic [15:0] FRAME_LIM = 16'(MAX_FRAME);
    localparam logic [DIW-1:0] TOP_IDX = DIW'(NDESC - 1);

    typedef struct packed {
        eng_state_e     st;
        logic           rx_run;
        logic           tx_run;
        logic [DIW-1:0] rx_idx;
        logic [DIW-1:0] tx_idx;
        logic [31:0]    ptr;
        logic [15:0]    len;
        logic [15:0]    cnt;
        logic [15:0]    stat;
        logic           trunc;
        logic           fcs;
        logic [7:0]     byte_q;
    } eng_t;

    eng_t q, d;
    logic [15:0] st0, rx_stat, rx_len;

    assign st0 = w0[31:16];

    always_comb begin
        d         = q;
        wb_we     = 1'b0;
        wb_idx    = q.rx_idx;
        wb_word   = '0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = q.ptr + {16'h0, q.cnt};
        mem_wdata = rx_data;
        rx_ready  = 1'b0;
        tx_valid  = 1'b0;
        tx_data   = q.byte_q;
        tx_last   = 1'b0;
        desc_idx  = (q.st == S_RX_FETCH) ? q.rx_idx : q.tx_idx;

        rx_len  = (q.cnt > BUF_LIM) ? BUF_LIM : q.cnt;
        rx_stat = q.stat;
        rx_stat[OWN_BIT]  = 1'b0;
        rx_stat[5:0]      = 6'h00;
        rx_stat[LAST_BIT] = 1'b1;
        rx_stat[ELEN_BIT] = q.trunc;
        rx_stat[EFCS_BIT] = q.fcs;

        unique case (q.st)
            S_IDLE: begin
                if (q.rx_run && rx_valid) d.st = S_RX_FETCH;
                else if (q.tx_run)        d.st = S_TX_FETCH;
            end
            S_RX_FETCH: begin
                if (!st0[OWN_BIT]) begin
                    d.rx_run = 1'b0;
                    d.st     = S_IDLE;
                end else begin
                    d.ptr   = w1;
                    d.stat  = st0;
                    d.cnt   = '0;
                    d.trunc = 1'b0;
                    d.fcs   = 1'b0;
                    d.st    = S_RX_DATA;
                end
            end
            S_RX_DATA: begin
                rx_ready = 1'b1;
                if (rx_valid) begin
                    if (q.cnt < BUF_LIM) begin
                        mem_req = 1'b1;
                        mem_we  = 1'b1;
                    end
                    if (q.cnt >= FRAME_LIM) d.trunc = 1'b1;
                    if (q.cnt != 16'hFFFF) d.cnt = q.cnt + 16'd1;
                    if (rx_last) begin
                        d.fcs = rx_fcs_bad;
                        d.st  = S_RX_WB;
                    end
                end
            end
            S_RX_WB: begin
                wb_we   = 1'b1;
                wb_idx  = q.rx_idx;
                wb_word = {rx_stat, rx_len};
                d.rx_idx = q.stat[WRAP_BIT] ? rx_base :
                           (q.rx_idx == TOP_IDX) ? '0 : q.rx_idx + 1'b1;
                d.st = S_IDLE;
            end
            S_TX_FETCH: begin
                if (!st0[OWN_BIT]) begin
                    d.tx_run = 1'b0;
                    d.st     = S_IDLE;
                end else begin
                    d.ptr  = w1;
                    d.stat = st0;
                    d.len  = w0[15:0];
                    d.cnt  = '0;
                    d.st   = (w0[15:0] == 16'd0) ? S_TX_WB : S_TX_RD;
                end
            end
            S_TX_RD: begin
                mem_req  = 1'b1;
                d.byte_q = mem_rdata;
                d.st     = S_TX_OUT;
            end
            S_TX_OUT: begin
                tx_valid = 1'b1;
                tx_last  = q.stat[LAST_BIT] && (q.cnt == q.len - 16'd1);
                if (tx_ready) begin
                    d.cnt = q.cnt + 16'd1;
                    d.st  = (q.cnt == q.len - 16'd1) ? S_TX_WB : S_TX_RD;
                end
            end
            S_TX_WB: begin
                wb_we   = 1'b1;
                wb_idx  = q.tx_idx;
                wb_word = {q.stat & ~(16'h1 << OWN_BIT), q.len};
                d.tx_idx = q.stat[WRAP_BIT] ? tx_base :
                           (q.tx_idx == TOP_IDX) ? '0 : q.tx_idx + 1'b1;
                d.st = S_IDLE;
            end
            default: d.st = S_IDLE;
        endcase

        if (rx_rebase) d.rx_idx = rebase_idx;
        if (tx_rebase) d.tx_idx = rebase_idx;
        if (rx_kick)   d.rx_run = 1'b1;
        if (tx_kick)   d.tx_run = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '{st: S_IDLE, default: '0};
        else        q <= d;
    end

    assign rx_run = q.rx_run;
    assign tx_run = q.tx_run;
endmodule

// File: rtl/bdring_dma.sv
module bdring_dma #(
    parameter int NDESC     = 8,
    parameter int MAX_BUF   = 1520,
    parameter int MAX_FRAME = 1518,
    localparam int IW  = $clog2(2 * NDESC),
    localparam int DIW = $clog2(NDESC),
    localparam int AW  = IW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_we,
    input  logic [AW-1:0] host_addr,
    input  logic [31:0]   host_wdata,
    output logic [31:0]   host_rdata,
    output logic          mem_req,
    output logic          mem_we,
    output logic [31:0]   mem_addr,
    output logic [7:0]    mem_wdata,
    input  logic [7:0]    mem_rdata,
    input  logic          rx_valid,
    input  logic [7:0]    rx_data,
    input  logic          rx_last,
    input  logic          rx_fcs_bad,
    output logic          rx_ready,
    output logic          tx_valid,
    output logic [7:0]    tx_data,
    output logic          tx_last,
    input  logic          tx_ready
);
    logic           reg_sel_w;
    logic           ram_we_w, reg_we_w;
    logic [31:0]    ram_rdata_w;
    logic [DIW-1:0] desc_idx_w, wb_idx_w, rx_base_w, tx_base_w;
    logic [31:0]    w0_w, w1_w, wb_word_w;
    logic           wb_we_w;
    logic           rx_kick_w, tx_kick_w, rx_rebase_w, tx_rebase_w;
    logic           rx_run_w, tx_run_w;

    assign reg_sel_w = host_addr[AW-1];
    assign ram_we_w  = host_we && !reg_sel_w;
    assign reg_we_w  = host_we && reg_sel_w;

    bdring_desc_ram #(.NDESC(NDESC)) u_ram (
        .clk(clk), .rst_n(rst_n),
        .host_we(ram_we_w), .host_idx(host_addr[IW-1:0]),
        .host_wdata(host_wdata), .host_rdata(ram_rdata_w),
        .eng_idx(desc_idx_w), .eng_w0(w0_w), .eng_w1(w1_w),
        .wb_we(wb_we_w), .wb_idx(wb_idx_w), .wb_word(wb_word_w)
    );

    bdring_regs #(.DIW(DIW)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(reg_we_w), .sel(host_addr[1:0]),
        .kick_bit(host_wdata[bdring_pkg::KICK_BIT]),
        .idx_in(host_wdata[DIW-1:0]),
        .rx_base(rx_base_w), .tx_base(tx_base_w),
        .rx_kick(rx_kick_w), .tx_kick(tx_kick_w),
        .rx_rebase(rx_rebase_w), .tx_rebase(tx_rebase_w)
    );

    bdring_engine #(.NDESC(NDESC), .MAX_BUF(MAX_BUF), .MAX_FRAME(MAX_FRAME)) u_eng (
        .clk(clk), .rst_n(rst_n),
        .rx_kick(rx_kick_w), .tx_kick(tx_kick_w),
        .rx_rebase(rx_rebase_w), .tx_rebase(tx_rebase_w),
        .rebase_idx(host_wdata[DIW-1:0]),
        .rx_base(rx_base_w), .tx_base(tx_base_w),
        .desc_idx(desc_idx_w), .w0(w0_w), .w1(w1_w),
        .wb_we(wb_we_w), .wb_idx(wb_idx_w), .wb_word(wb_word_w),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last),
        .rx_fcs_bad(rx_fcs_bad), .rx_ready(rx_ready),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last),
        .tx_ready(tx_ready),
        .rx_run(rx_run_w), .tx_run(tx_run_w)
    );

    always_comb begin
        host_rdata = ram_rdata_w;
        if (reg_sel_w) begin
            unique case (host_addr[1:0])
                2'd0: host_rdata = {{(32-DIW){1'b0}}, rx_base_w};
                2'd1: host_rdata = {{(32-DIW){1'b0}}, tx_base_w};
                2'd2: host_rdata = {7'h0, rx_run_w, 24'h0};
                2'd3: host_rdata = {7'h0, tx_run_w, 24'h0};
            endcase
        end
    end
endmodule

// File: rtl/bdring_dma_chk.sv
module bdring_dma_chk #(
    parameter int AW = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          host_we,
    input logic [AW-1:0] host_addr,
    input logic [31:0]   host_wdata,
    input logic          mem_req,
    input logic          mem_we,
    input logic          rx_valid,
    input logic          rx_ready,
    input logic          tx_valid,
    input logic [7:0]    tx_data,
    input logic          tx_last,
    input logic          tx_ready,
    input logic          rx_run
);
    localparam logic [AW-1:0] RX_ACT = AW'((1 << (AW - 1)) | 2);

    // R3: a buffer write happens only as a receive byte is taken
    a_r3_write_with_byte: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (rx_valid && rx_ready));

    // R8: a stalled transmit byte holds steady
    a_r8_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));

    // R8: last marker only on a presented byte
    a_r8_last_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        tx_last |-> tx_valid);

    // R5: the receive stream is open only while the ring runs
    a_r5_ready_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ready |-> rx_run);

    // R2: an activation write without bit 24 leaves a stopped ring stopped
    a_r2_bad_kick_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (host_we && host_addr == RX_ACT && !host_wdata[24] && !rx_run) |=> !rx_run);

    // R8: the shared sequencer never serves both streams at once
    a_r8_one_stream: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_ready && tx_valid));
endmodule

bind bdring_dma bdring_dma_chk #(.AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
    .mem_req(mem_req), .mem_we(mem_we),
    .rx_valid(rx_valid), .rx_ready(rx_ready),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last),
    .tx_ready(tx_ready), .rx_run(rx_run_w)
);

// File: tb/bdring_dma_tb.sv
module bdring_dma_tb;
    localparam int AW = 5;
    localparam logic [AW-1:0] A_RXB = 5'h10;
    localparam logic [AW-1:0] A_TXB = 5'h11;
    localparam logic [AW-1:0] A_RXA = 5'h12;
    localparam logic [AW-1:0] A_TXA = 5'h13;
    localparam logic [31:0] KICK = 32'h0100_0000;

    logic clk = 1'b0, rst_n = 1'b0;
    logic host_we = 1'b0;
    logic [AW-1:0] host_addr = '0;
    logic [31:0] host_wdata = '0, host_rdata;
    logic mem_req, mem_we;
    logic [31:0] mem_addr;
    logic [7:0] mem_wdata, mem_rdata = '0;
    logic rx_valid = 1'b0, rx_last = 1'b0, rx_fcs_bad = 1'b0, rx_ready;
    logic [7:0] rx_data = '0;
    logic tx_valid, tx_last, tx_ready = 1'b1;
    logic [7:0] tx_data;

    int checks = 0, errors = 0;
    logic [7:0] mem [0:8191];
    logic [8:0] exp_q [$];
    bit stall = 1'b0;
    int tcnt = 0;

    always #5 clk = ~clk;

    bdring_dma u_dut (
        .clk(clk), .rst_n(rst_n),
        .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rdata(host_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last),
        .rx_fcs_bad(rx_fcs_bad), .rx_ready(rx_ready),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last),
        .tx_ready(tx_ready)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int seed, input int i);
        return 8'(seed + i * 7 + (i >> 8));
    endfunction

    // buffer memory model: serves the request at mid-cycle
    always @(negedge clk) begin
        if (mem_req) begin
            if (mem_we) mem[mem_addr[12:0]] = mem_wdata;
            else        mem_rdata = mem[mem_addr[12:0]];
        end
    end

    always @(posedge clk) begin
        #2;
        tcnt++;
        tx_ready = stall ? (tcnt % 3 != 0) : 1'b1;
    end

    // transmit monitor: pops the scoreboard on every accepted byte
    always @(negedge clk) begin
        if (rst_n && tx_valid && tx_ready) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R8 unexpected tx byte", {23'h0, tx_last, tx_data}, 32'h0);
            end else begin
                logic [8:0] e;
                e = exp_q.pop_front();
                chk({tx_last, tx_data} == e, "R8 tx byte/last", {23'h0, tx_last, tx_data}, {23'h0, e});
            end
        end
    end

    task automatic hwr(input logic [AW-1:0] a, input logic [31:0] dt);
        @(posedge clk); #2;
        host_we = 1'b1; host_addr = a; host_wdata = dt;
        @(posedge clk); #2;
        host_we = 1'b0;
    endtask

    task automatic hrd(input logic [AW-1:0] a, output logic [31:0] dt);
        @(posedge clk); #2;
        host_addr = a;
        @(negedge clk);
        dt = host_rdata;
    endtask

    task automatic set_desc(input int di, input logic [15:0] st, input logic [15:0] ln, input logic [31:0] p);
        hwr(AW'(2 * di + 1), p);
        hwr(AW'(2 * di), {st, ln});
    endtask

    task automatic rx_frame(input int n, input int seed, input bit bad, input string tag);
        bit to = 1'b0;
        for (int i = 0; i < n && !to; i++) begin
            int k = 0;
            @(posedge clk); #2;
            rx_valid = 1'b1; rx_data = pat(seed, i);
            rx_last = (i == n - 1); rx_fcs_bad = bad && (i == n - 1);
            @(negedge clk);
            while (!rx_ready && k < 3000) begin @(negedge clk); k++; end
            if (k >= 3000) to = 1'b1;
            @(posedge clk); #2;
            rx_valid = 1'b0; rx_last = 1'b0; rx_fcs_bad = 1'b0;
        end
        if (to) chk(1'b0, {tag, " receive byte not accepted"}, 32'h0, 32'h1);
        repeat (3) @(posedge clk);
    endtask

    task automatic chk_mem(input int base, input int n, input int seed, input string tag);
        int bad = 0;
        int first = -1;
        for (int i = 0; i < n; i++)
            if (mem[base + i] !== pat(seed, i)) begin
                bad++;
                if (first < 0) first = i;
            end
        chk(bad == 0, tag, 32'(first), 32'(bad));
    endtask

    task automatic chk_word(input int widx, input logic [31:0] exp, input string tag);
        logic [31:0] v;
        hrd(AW'(widx), v);
        chk(v == exp, tag, v, exp);
    endtask

    task automatic hold_rx_check(input string tag);
        bit seen = 1'b0;
        @(posedge clk); #2;
        rx_valid = 1'b1; rx_data = 8'h55; rx_last = 1'b1;
        repeat (20) begin
            @(negedge clk);
            if (rx_ready) seen = 1'b1;
        end
        @(posedge clk); #2;
        rx_valid = 1'b0; rx_last = 1'b0;
        chk(!seen, tag, {31'h0, seen}, 32'h0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        for (int i = 0; i < 8192; i++) mem[i] = 8'hEE;
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(!rx_ready && !tx_valid && !mem_req, "R1 outputs idle", {29'h0, rx_ready, tx_valid, mem_req}, 32'h0);
        hrd(A_RXA, v); chk(v == 32'h0, "R1 rx stopped", v, 32'h0);
        hrd(A_TXA, v); chk(v == 32'h0, "R1 tx stopped", v, 32'h0);
        hrd(A_RXB, v); chk(v == 32'h0, "R1 rx start index", v, 32'h0);

        // receive ring: d0, d1 plain; d2 carries wrap
        set_desc(0, 16'h8000, 16'h0, 32'h100);
        set_desc(1, 16'h8000, 16'h0, 32'h200);
        set_desc(2, 16'hA000, 16'h0, 32'h300);
        hwr(A_RXB, 32'h0);

        // R2 activation without bit 24 has no effect
        hwr(A_RXA, 32'h0000_0001);
        hrd(A_RXA, v); chk(v == 32'h0, "R2 bad kick readback", v, 32'h0);
        hold_rx_check("R2 bad kick accepts no byte");
        hwr(A_RXA, KICK);
        hrd(A_RXA, v); chk(v == KICK, "R2 kick starts ring", v, KICK);

        // R3/R4 good frame
        rx_frame(10, 3, 1'b0, "R3");
        chk_mem(32'h100, 10, 3, "R3 frame bytes stored in order");
        chk_word(0, {16'h0800, 16'd10}, "R4 good status, R3 length");
        // R4 check-sequence error flag
        rx_frame(6, 40, 1'b1, "R4");
        chk_word(2, {16'h0804, 16'd6}, "R4 fcs error bit 2");
        // wrap descriptor
        rx_frame(64, 90, 1'b0, "R4w");
        chk_mem(32'h300, 64, 90, "R3 third buffer");
        chk_word(4, {16'h2800, 16'd64}, "R4 wrap bit kept");

        // R5 next is d0 (not empty): ring stops
        hold_rx_check("R5 stopped ring accepts no byte");
        hrd(A_RXA, v); chk(v == 32'h0, "R5 stopped readback", v, 32'h0);

        // R7 re-arm d0, resume: frame must land in d0
        set_desc(0, 16'h8000, 16'h0, 32'h400);
        hwr(A_RXA, KICK);
        rx_frame(4, 17, 1'b0, "R7");
        chk_mem(32'h400, 4, 17, "R7 wrap returns to start index");
        chk_word(0, {16'h0800, 16'd4}, "R7 d0 written back");

        // R6 long frame into d1
        set_desc(1, 16'h8000, 16'h0, 32'h1000);
        rx_frame(1522, 5, 1'b0, "R6");
        chk_word(2, {16'h0820, 16'd1520}, "R6 truncated length and flag");
        chk_mem(32'h1000, 1520, 5, "R6 stored prefix");
        chk(mem[32'h1000 + 1520] == 8'hEE, "R6 no byte beyond buffer", {24'h0, mem[32'h1000 + 1520]}, 32'hEE);
        // R6 boundary: exactly max frame length
        set_desc(2, 16'hA000, 16'h0, 32'h1800);
        rx_frame(1518, 77, 1'b0, "R6b");
        chk_word(4, {16'h2800, 16'd1518}, "R6 max-length frame not flagged");

        // R11 new start index
        set_desc(4, 16'h8000, 16'h0, 32'h600);
        hwr(A_RXB, 32'd4);
        rx_frame(3, 200, 1'b0, "R11");
        chk_mem(32'h600, 3, 200, "R11 frame lands at new start");
        chk_word(8, {16'h0800, 16'd3}, "R11 descriptor at new start");

        // transmit ring at start index 5
        for (int i = 0; i < 5; i++) mem[32'h1C00 + i] = pat(9, i);
        for (int i = 0; i < 3; i++) mem[32'h1D00 + i] = pat(60, i);
        set_desc(5, 16'h8800, 16'd5, 32'h1C00);
        set_desc(6, 16'h8100, 16'd3, 32'h1D00);
        set_desc(7, 16'hA800, 16'd0, 32'h1E00);
        hwr(A_TXB, 32'd5);
        for (int i = 0; i < 5; i++) exp_q.push_back({i == 4, pat(9, i)});
        for (int i = 0; i < 3; i++) exp_q.push_back({1'b0, pat(60, i)});
        stall = 1'b1;
        hwr(A_TXA, KICK);
        begin
            int k = 0;
            v = KICK;
            while (v != 32'h0 && k < 2000) begin hrd(A_TXA, v); k++; end
        end
        chk(v == 32'h0, "R10 tx ring stops at unready descriptor", v, 32'h0);
        chk(exp_q.size() == 0, "R8 all bytes sent", 32'(exp_q.size()), 32'h0);
        chk_word(10, {16'h0800, 16'd5}, "R9 first tx released");
        chk_word(12, {16'h0100, 16'd3}, "R9 other bits kept");
        chk_word(14, {16'h2800, 16'd0}, "R12 zero length released");
        @(negedge clk);
        chk(!tx_valid, "R10 no output when stopped", {31'h0, tx_valid}, 32'h0);

        // R7 transmit wrap returns to start index 5
        stall = 1'b0;
        for (int i = 0; i < 2; i++) mem[32'h1F00 + i] = pat(33, i);
        set_desc(5, 16'h8800, 16'd2, 32'h1F00);
        for (int i = 0; i < 2; i++) exp_q.push_back({i == 1, pat(33, i)});
        hwr(A_TXA, KICK);
        repeat (30) @(posedge clk);
        chk(exp_q.size() == 0, "R7 tx wrap to start index", 32'(exp_q.size()), 32'h0);
        chk_word(10, {16'h0800, 16'd2}, "R7 tx d5 released again");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule